// File: doc/BRIEF.md
# Four-Stage Pipelined Floating-Point Adder

This block adds or subtracts two floating-point operands in a four-stage pipeline. Each operand has a sign bit, an unsigned exponent and a fractional mantissa. The value of an operand is 0.m times 2^e. A normalized mantissa has its top bit set, and a mantissa of zero means the value zero. The four stages are exponent compare, mantissa align, mantissa add or subtract, and normalize. Each stage ends in a register, so a new operand pair can enter on every clock. Results leave in the order their operands arrived.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream. Back-pressure works as one global stall. When a result is waiting and the consumer does not take it, every stage holds and `in_ready` drops. At all other times the pipeline advances and `in_ready` stays high, so the producer can send at full rate. Alignment drops the bits it shifts out, and the block does no rounding. Two flags mark exponent overflow and underflow.

Top module: `fpadd_pipe`

## Requirements
- R1: An operand pair accepted in cycle t produces its result with `out_valid` high in cycle t+4, provided no stall occurs, and results leave in acceptance order.
- R2: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and every output data bit hold steady, and no new pair is accepted.
- R3: The larger exponent becomes the working exponent, and operand A wins a tie. The other mantissa is shifted right by the exponent difference and the shifted-out bits are dropped. A difference of MAN_W or more gives an aligned mantissa of zero.
- R4: `in_op` = 0 computes A + B and `in_op` = 1 computes A - B. Subtraction is done by inverting the sign of B.
- R5: Magnitudes are combined in sign-magnitude form. When the signs differ and the aligned smaller-exponent mantissa is larger, the magnitude of the difference is used and the result sign is the inverse of the larger-exponent operand's sign.
- R6: When the magnitude sum carries out of MAN_W bits, the mantissa is shifted right one place and the exponent rises by one.
- R7: When the magnitude has leading zeros, they are removed by a left shift, and the exponent is reduced by the shift amount. A result that is already normalized passes through unchanged.
- R8: A zero magnitude gives sign 0, exponent 0, mantissa 0 and both flags clear.
- R9: When a carry-out occurs with the exponent already at its maximum, `out_ovf` is 1, the exponent stays at its maximum and the mantissa is the shifted sum.
- R10: When the leading-zero count exceeds the working exponent, `out_unf` is 1 and sign, exponent and mantissa are all zero. `out_ovf` and `out_unf` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Pipeline can accept a pair this cycle |
| in_op | input | 1 | 0 add, 1 subtract |
| in_a_sign | input | 1 | Sign of A |
| in_a_exp | input | EXP_W | Exponent of A |
| in_a_man | input | MAN_W | Mantissa of A |
| in_b_sign | input | 1 | Sign of B |
| in_b_exp | input | EXP_W | Exponent of B |
| in_b_man | input | MAN_W | Mantissa of B |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W | Result exponent |
| out_man | output | MAN_W | Result mantissa |
| out_ovf | output | 1 | Exponent overflow |
| out_unf | output | 1 | Exponent underflow, result flushed to zero |

## Verification
A wrong swap decision or a wrong shift amount in the first two stages shows up as a wrong mantissa or exponent. It appears on the very result that carries it, exactly four cycles after that pair went in. A broken stall enable shows up in a different way: results are lost, duplicated or reordered the first time `out_ready` drops. The exhaustive sweep compares every output against the queue of expected results in order, so a single slip is caught at the next handshake. A fault in the normalize stage shows up as a clear top mantissa bit, a stale exponent on a zero result, or a wrong flag, all in the same cycle.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int unsigned FPA_STAGES = 4;
  typedef enum logic {FPA_ADD = 1'b0, FPA_SUB = 1'b1} fpa_op_e;
endpackage

// File: rtl/fpadd_cmp.sv
module fpadd_cmp #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             i_valid,
  input  logic             i_op,
  input  logic             i_a_s,
  input  logic [EXP_W-1:0] i_a_e,
  input  logic [MAN_W-1:0] i_a_m,
  input  logic             i_b_s,
  input  logic [EXP_W-1:0] i_b_e,
  input  logic [MAN_W-1:0] i_b_m,
  output logic             o_valid,
  output logic             o_big_s,
  output logic [EXP_W-1:0] o_big_e,
  output logic [MAN_W-1:0] o_big_m,
  output logic             o_sml_s,
  output logic [MAN_W-1:0] o_sml_m,
  output logic [EXP_W-1:0] o_shamt
);
  import fpadd_pkg::*;
  logic [EXP_W:0]   diff;
  logic             a_wins;
  logic             b_s_eff;

  always_comb begin
    diff    = {1'b0, i_a_e} - {1'b0, i_b_e};
    a_wins  = ~diff[EXP_W];
    b_s_eff = i_b_s ^ (i_op == FPA_SUB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_big_s <= 1'b0;
      o_big_e <= '0;
      o_big_m <= '0;
      o_sml_s <= 1'b0;
      o_sml_m <= '0;
      o_shamt <= '0;
    end else if (en) begin
      o_valid <= i_valid;
      if (a_wins) begin
        o_big_s <= i_a_s;
        o_big_e <= i_a_e;
        o_big_m <= i_a_m;
        o_sml_s <= b_s_eff;
        o_sml_m <= i_b_m;
        o_shamt <= diff[EXP_W-1:0];
      end else begin
        o_big_s <= b_s_eff;
        o_big_e <= i_b_e;
        o_big_m <= i_b_m;
        o_sml_s <= i_a_s;
        o_sml_m <= i_a_m;
        o_shamt <= i_b_e - i_a_e;
      end
    end
  end
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             i_valid,
  input  logic             i_big_s,
  input  logic [EXP_W-1:0] i_big_e,
  input  logic [MAN_W-1:0] i_big_m,
  input  logic             i_sml_s,
  input  logic [MAN_W-1:0] i_sml_m,
  input  logic [EXP_W-1:0] i_shamt,
  output logic             o_valid,
  output logic             o_big_s,
  output logic [EXP_W-1:0] o_big_e,
  output logic [MAN_W-1:0] o_big_m,
  output logic             o_sml_s,
  output logic [MAN_W-1:0] o_al_m
);
  logic [MAN_W-1:0] shifted;

  always_comb begin
    if (32'(i_shamt) >= MAN_W) shifted = '0;
    else                       shifted = i_sml_m >> i_shamt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_big_s <= 1'b0;
      o_big_e <= '0;
      o_big_m <= '0;
      o_sml_s <= 1'b0;
      o_al_m  <= '0;
    end else if (en) begin
      o_valid <= i_valid;
      o_big_s <= i_big_s;
      o_big_e <= i_big_e;
      o_big_m <= i_big_m;
      o_sml_s <= i_sml_s;
      o_al_m  <= shifted;
    end
  end

  // R3: a right shift never enlarges the smaller mantissa
  assert_align_shrink_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && i_valid) |=> (o_al_m <= $past(i_sml_m)));
endmodule

// File: rtl/fpadd_addsub.sv
module fpadd_addsub #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             i_valid,
  input  logic             i_big_s,
  input  logic [EXP_W-1:0] i_big_e,
  input  logic [MAN_W-1:0] i_big_m,
  input  logic             i_sml_s,
  input  logic [MAN_W-1:0] i_al_m,
  output logic             o_valid,
  output logic             o_s,
  output logic [EXP_W-1:0] o_e,
  output logic [MAN_W:0]   o_mag
);
  logic [MAN_W:0] raw;
  logic [MAN_W:0] mag;
  logic           sgn;

  always_comb begin
    if (i_big_s == i_sml_s) begin
      raw = {1'b0, i_big_m} + {1'b0, i_al_m};
      mag = raw;
      sgn = i_big_s;
    end else begin
      raw = {1'b0, i_big_m} - {1'b0, i_al_m};
      if (raw[MAN_W]) begin
        mag = -raw;
        sgn = ~i_big_s;
      end else begin
        mag = raw;
        sgn = i_big_s;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_s     <= 1'b0;
      o_e     <= '0;
      o_mag   <= '0;
    end else if (en) begin
      o_valid <= i_valid;
      o_s     <= sgn;
      o_e     <= i_big_e;
      o_mag   <= mag;
    end
  end

  // R5: a difference of operands with unlike signs never carries out
  assert_diff_no_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && i_valid && (i_big_s != i_sml_s)) |=> !o_mag[MAN_W]);
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             i_valid,
  input  logic             i_s,
  input  logic [EXP_W-1:0] i_e,
  input  logic [MAN_W:0]   i_mag,
  output logic             o_valid,
  output logic             o_s,
  output logic [EXP_W-1:0] o_e,
  output logic [MAN_W-1:0] o_m,
  output logic             o_ovf,
  output logic             o_unf
);
  localparam int unsigned LZ_W  = $clog2(MAN_W + 1);
  localparam int unsigned CMP_W = (LZ_W > EXP_W) ? LZ_W : EXP_W;
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  logic [LZ_W-1:0]  lz;
  logic             n_s, n_ovf, n_unf;
  logic [EXP_W-1:0] n_e;
  logic [MAN_W-1:0] n_m;

  always_comb begin
    lz = LZ_W'(MAN_W);
    for (int i = 0; i < MAN_W; i++) begin
      if (i_mag[i]) lz = LZ_W'(MAN_W - 1 - i);
    end
  end

  always_comb begin
    n_s = i_s; n_e = i_e; n_m = i_mag[MAN_W-1:0];
    n_ovf = 1'b0; n_unf = 1'b0;
    if (i_mag[MAN_W]) begin
      n_m = i_mag[MAN_W:1];
      if (i_e == EXP_MAX) n_ovf = 1'b1;
      else                n_e   = i_e + 1'b1;
    end else if (i_mag == '0) begin
      n_s = 1'b0; n_e = '0; n_m = '0;
    end else if (CMP_W'(lz) > CMP_W'(i_e)) begin
      n_s = 1'b0; n_e = '0; n_m = '0; n_unf = 1'b1;
    end else begin
      n_m = i_mag[MAN_W-1:0] << lz;
      n_e = i_e - EXP_W'(lz);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_s     <= 1'b0;
      o_e     <= '0;
      o_m     <= '0;
      o_ovf   <= 1'b0;
      o_unf   <= 1'b0;
    end else if (en) begin
      o_valid <= i_valid;
      o_s     <= n_s;
      o_e     <= n_e;
      o_m     <= n_m;
      o_ovf   <= n_ovf;
      o_unf   <= n_unf;
    end
  end

  // R7: every nonzero result leaves normalized
  assert_norm_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && (o_m != '0)) |-> o_m[MAN_W-1]);
  // R8: zero result carries clean sign, exponent and overflow flag
  assert_zero_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && (o_m == '0)) |-> ((o_e == '0) && !o_s && !o_ovf));
  // R10: flags are mutually exclusive
  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> !(o_ovf && o_unf));
endmodule

// File: rtl/fpadd_pipe.sv
module fpadd_pipe #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_op,
  input  logic             in_a_sign,
  input  logic [EXP_W-1:0] in_a_exp,
  input  logic [MAN_W-1:0] in_a_man,
  input  logic             in_b_sign,
  input  logic [EXP_W-1:0] in_b_exp,
  input  logic [MAN_W-1:0] in_b_man,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_sign,
  output logic [EXP_W-1:0] out_exp,
  output logic [MAN_W-1:0] out_man,
  output logic             out_ovf,
  output logic             out_unf
);
  logic en;
  logic             v1, bs1, ss1;
  logic [EXP_W-1:0] be1, sh1;
  logic [MAN_W-1:0] bm1, sm1;
  logic             v2, bs2, ss2;
  logic [EXP_W-1:0] be2;
  logic [MAN_W-1:0] bm2, am2;
  logic             v3, s3;
  logic [EXP_W-1:0] e3;
  logic [MAN_W:0]   mag3;

  assign en       = ~out_valid | out_ready;
  assign in_ready = en;

  fpadd_cmp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .en(en), .i_valid(in_valid), .i_op(in_op),
    .i_a_s(in_a_sign), .i_a_e(in_a_exp), .i_a_m(in_a_man),
    .i_b_s(in_b_sign), .i_b_e(in_b_exp), .i_b_m(in_b_man),
    .o_valid(v1), .o_big_s(bs1), .o_big_e(be1), .o_big_m(bm1),
    .o_sml_s(ss1), .o_sml_m(sm1), .o_shamt(sh1));

  fpadd_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
    .clk(clk), .rst_n(rst_n), .en(en), .i_valid(v1),
    .i_big_s(bs1), .i_big_e(be1), .i_big_m(bm1),
    .i_sml_s(ss1), .i_sml_m(sm1), .i_shamt(sh1),
    .o_valid(v2), .o_big_s(bs2), .o_big_e(be2), .o_big_m(bm2),
    .o_sml_s(ss2), .o_al_m(am2));

  fpadd_addsub #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_addsub (
    .clk(clk), .rst_n(rst_n), .en(en), .i_valid(v2),
    .i_big_s(bs2), .i_big_e(be2), .i_big_m(bm2),
    .i_sml_s(ss2), .i_al_m(am2),
    .o_valid(v3), .o_s(s3), .o_e(e3), .o_mag(mag3));

  fpadd_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
    .clk(clk), .rst_n(rst_n), .en(en), .i_valid(v3),
    .i_s(s3), .i_e(e3), .i_mag(mag3),
    .o_valid(out_valid), .o_s(out_sign), .o_e(out_exp), .o_m(out_man),
    .o_ovf(out_ovf), .o_unf(out_unf));

  // R2: a refused result stays put
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable({out_sign, out_exp, out_man, out_ovf, out_unf})));
  // R2: an empty output slot always admits input
  assert_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

// File: tb/sim_fpadd_pipe.sv
`timescale 1ns/1ps
module sim_fpadd_pipe;
  localparam int EW = 3;
  localparam int MW = 4;
  localparam int RW = 1 + EW + MW + 2;
  localparam int NOPD = 144;
  localparam int NV = 2 * NOPD * NOPD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_op = 1'b0, out_ready = 1'b1;
  logic in_a_sign = 1'b0, in_b_sign = 1'b0;
  logic [EW-1:0] in_a_exp = '0, in_b_exp = '0;
  logic [MW-1:0] in_a_man = '0, in_b_man = '0;
  logic in_ready, out_valid, out_sign, out_ovf, out_unf;
  logic [EW-1:0] out_exp;
  logic [MW-1:0] out_man;

  int checks = 0;
  int failures = 0;
  logic [RW-1:0] expq[$];
  string tagq[$];

  always #4 clk = ~clk;

  fpadd_pipe #(.EXP_W(EW), .MAN_W(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a_sign(in_a_sign), .in_a_exp(in_a_exp), .in_a_man(in_a_man),
    .in_b_sign(in_b_sign), .in_b_exp(in_b_exp), .in_b_man(in_b_man),
    .out_valid(out_valid), .out_ready(out_ready), .out_sign(out_sign),
    .out_exp(out_exp), .out_man(out_man), .out_ovf(out_ovf), .out_unf(out_unf));

  function automatic logic [RW-1:0] model(input int op, input int sa, input int ea,
      input int ma, input int sb, input int eb, input int mb, output string tag);
    int bs, be, bm, ss, sm, d, al, r, s, e, m, lz, ovf, unf;
    sb = sb ^ op;
    if (ea >= eb) begin bs = sa; be = ea; bm = ma; ss = sb; sm = mb; d = ea - eb; end
    else          begin bs = sb; be = eb; bm = mb; ss = sa; sm = ma; d = eb - ea; end
    al = (d >= MW) ? 0 : (sm >> d);
    tag = (op != 0) ? "R4" : "R3";
    s = bs;
    if (bs == ss) r = bm + al;
    else begin
      r = bm - al;
      if (r < 0) begin r = -r; s = 1 - bs; tag = "R5"; end
    end
    e = be; ovf = 0; unf = 0; m = r;
    if (r == 0) begin s = 0; e = 0; m = 0; tag = "R8"; end
    else if (r >= (1 << MW)) begin
      m = r >> 1;
      if (e == (1 << EW) - 1) begin ovf = 1; tag = "R9"; end
      else begin e = e + 1; tag = "R6"; end
    end else begin
      lz = 0;
      while (m < (1 << (MW - 1))) begin m = m * 2; lz++; end
      if (lz > e) begin s = 0; e = 0; m = 0; unf = 1; tag = "R10"; end
      else begin e = e - lz; if (lz > 0) tag = "R7"; end
    end
    return {s[0], e[EW-1:0], m[MW-1:0], ovf[0], unf[0]};
  endfunction

  function automatic int opd_man(input int k);
    int mi;
    mi = k / 16;
    return (mi == 0) ? 0 : (8 + mi - 1);
  endfunction

  task automatic drive(input int v);
    int op, rem, ka, kb;
    op = v / (NOPD * NOPD); rem = v % (NOPD * NOPD);
    ka = rem / NOPD; kb = rem % NOPD;
    in_op = op[0];
    in_a_sign = ka[0]; in_a_exp = EW'((ka / 2) % 8); in_a_man = MW'(opd_man(ka));
    in_b_sign = kb[0]; in_b_exp = EW'((kb / 2) % 8); in_b_man = MW'(opd_man(kb));
  endtask

  function automatic logic [RW-1:0] model_cur(output string tag);
    return model(int'(in_op), int'(in_a_sign), int'(in_a_exp), int'(in_a_man),
                 int'(in_b_sign), int'(in_b_exp), int'(in_b_man), tag);
  endfunction

  function automatic logic [RW-1:0] outvec();
    return {out_sign, out_exp, out_man, out_ovf, out_unf};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input int first, input int last, input bit bp);
    int v = first;
    int cyc = 0;
    logic [RW-1:0] e;
    string t;
    while (v < last || expq.size() > 0) begin
      @(negedge clk);
      out_ready = bp ? ((cyc % 5) != 2) : 1'b1;
      cyc++;
      if (v < last) begin drive(v); in_valid = 1'b1; end
      else in_valid = 1'b0;
      #1;
      if (in_ready !== (!out_valid || out_ready))
        check(1'b0, "R2", "in_ready rule", RW'(in_ready), RW'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (expq.size() == 0) check(1'b0, "R1", "unexpected result", outvec(), '0);
        else begin
          e = expq.pop_front(); t = tagq.pop_front();
          if (bp) t = {t, "/R2"};
          check(outvec() === e, t, "result", outvec(), e);
        end
      end
      if (in_valid && in_ready) begin
        e = model_cur(t);
        expq.push_back(e); tagq.push_back(t);
        v++;
      end
    end
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b1;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [RW-1:0] e;
    string t;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1", "reset out_valid", RW'(out_valid), '0);
    check(in_ready === 1'b1, "R2", "reset in_ready", RW'(in_ready), RW'(1));
    rst_n = 1'b1;
    @(negedge clk);

    // R1: latency of exactly four cycles
    in_valid = 1'b1; in_op = 1'b0;
    in_a_sign = 1'b0; in_a_exp = 3'd3; in_a_man = 4'b1010;
    in_b_sign = 1'b0; in_b_exp = 3'd2; in_b_man = 4'b1100;
    e = model_cur(t);
    @(negedge clk); in_valid = 1'b0;
    for (int i = 1; i <= 3; i++) begin
      check(out_valid === 1'b0, "R1", "early valid", RW'(out_valid), '0);
      @(negedge clk);
    end
    check(out_valid === 1'b1, "R1", "valid at cycle 4", RW'(out_valid), RW'(1));
    check(outvec() === e, "R1", "latency result", outvec(), e);
    @(negedge clk);
    check(out_valid === 1'b0, "R1", "single result", RW'(out_valid), '0);

    // R2: stall holds the result and blocks input
    out_ready = 1'b0; in_valid = 1'b1; in_op = 1'b1;
    in_a_sign = 1'b0; in_a_exp = 3'd2; in_a_man = 4'b1000;
    in_b_sign = 1'b0; in_b_exp = 3'd2; in_b_man = 4'b1111;
    e = model_cur(t);
    @(negedge clk); in_valid = 1'b0;
    repeat (6) @(negedge clk);
    check(out_valid === 1'b1, "R2", "held valid", RW'(out_valid), RW'(1));
    check(in_ready === 1'b0, "R2", "stalled in_ready", RW'(in_ready), '0);
    check(outvec() === e, "R2", "held data", outvec(), e);
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R2", "drained", RW'(out_valid), '0);

    run(0, NV, 1'b0);
    run(0, 3000, 1'b1);
    run(NV - 3000, NV, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule